// File: doc/BRIEF.md
# True-Color Pixel Path with Overlay Priority

This block converts a 16-bit direct-color pixel word into a 24-bit RGB value for a display output stage. Each pixel word holds three 5-bit color channels and one overlay bit. The block widens each channel to 8 bits with no palette lookup. The overlay field is the index into a small internal table of 24-bit colors. A zero index lets the widened direct color through. A non-zero index replaces the direct color with the table entry.

The blank and the two sync signals travel through a delay line with the same number of stages as the pixel path. Timing at the output stays aligned with the color it belongs to. While blank is active the color output is held at black. A write port loads table entries. A lookup made in the same cycle as a write to its entry already sees the new color.

Top module: `tc_overlay_path`

## Requirements
- R1: Pixel word layout is fixed: bit 15 is the overlay field, bits 14:10 red, 9:5 green and 4:0 blue. The output packs red in rgb_o[23:16], green in rgb_o[15:8] and blue in rgb_o[7:0].
- R2: A 5-bit channel c becomes the 8-bit value {c[4:0], c[4:2]}, so 0 gives 0x00 and 31 gives 0xFF.
- R3: When the overlay field is zero and blank is low, rgb_o carries the widened direct color.
- R4: When the overlay field is non-zero and blank is low, rgb_o carries the table entry at the overlay index instead of the direct color.
- R5: A pixel sampled at rising edge k shows at rgb_o after rising edge k+1. That is two register stages, one for the table read and one for the output select.
- R6: blank_o, hsync_o and vsync_o reproduce blank_i, hsync_i and vsync_i with exactly the same two-stage delay as the color.
- R7: While blank_o is high, rgb_o is 0 whatever the pixel and overlay were.
- R8: With tbl_we_i high at edge k, tbl_data_i is stored at tbl_addr_i. A lookup of that entry sampled at the same edge k already returns tbl_data_i.
- R9: Reset is synchronous and active high. It drives rgb_o to 0, blank_o to 1 and both syncs to 0, and it clears every table entry to 0.
- R10: Writing table entry 0 has no visible effect on pixels whose overlay field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | 16 | Pixel word: overlay, red, green, blue |
| blank_i | input | 1 | Blank, active high |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 1 | Table entry index to write |
| tbl_data_i | input | 24 | Color to write, same packing as rgb_o |
| rgb_o | output | 24 | Output color |
| blank_o | output | 1 | Delayed blank |
| hsync_o | output | 1 | Delayed horizontal sync |
| vsync_o | output | 1 | Delayed vertical sync |

## Verification
The alignment and pass-through properties compare each output with the input from two edges earlier. They apply only once two edges in a row have passed with reset low, so they assume every input word is a defined value from the first edge after reset. The stimulus drives every input to a known value on each cycle, and only on falling edges. Table writes can arrive in any cycle. The stimulus puts them next to the lookups, at the same index and on entry 0, so that the forwarding case and the unused-entry case both occur.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int CH_W      = 5;
    localparam int OUT_CH_W  = 8;
    localparam int OVL_W     = 1;
    localparam int PIX_W     = OVL_W + 3 * CH_W;
    localparam int RGB_W     = 3 * OUT_CH_W;
    localparam int TBL_DEPTH = 1 << OVL_W;
    localparam int PIPE_LEN  = 2;

    typedef logic [OVL_W-1:0]    ovl_t;
    typedef logic [CH_W-1:0]     chn_t;
    typedef logic [OUT_CH_W-1:0] chw_t;

    typedef struct packed {
        ovl_t ovl;
        chn_t r;
        chn_t g;
        chn_t b;
    } pix_t;

    typedef struct packed {
        chw_t r;
        chw_t g;
        chw_t b;
    } rgb_t;

    typedef struct packed {
        logic blank;
        logic hsync;
        logic vsync;
    } vctl_t;

    localparam vctl_t VCTL_IDLE = '{blank: 1'b1, hsync: 1'b0, vsync: 1'b0};

    // widen a channel by replicating its upper bits into the freed low bits
    function automatic chw_t widen(input chn_t c);
        return {c, c[CH_W-1 -: (OUT_CH_W - CH_W)]};
    endfunction

    function automatic rgb_t widen_pix(input pix_t p);
        rgb_t o;
        o.r = widen(p.r);
        o.g = widen(p.g);
        o.b = widen(p.b);
        return o;
    endfunction

endpackage

// File: rtl/tc_expand.sv
module tc_expand
    import tc_pkg::*;
(
    input  pix_t pix,
    output rgb_t rgb,
    output logic ovl_hit
);
    always_comb begin
        rgb     = widen_pix(pix);
        ovl_hit = |pix.ovl;
    end
endmodule

// File: rtl/tc_ovl_table.sv
module tc_ovl_table
    import tc_pkg::*;
#(
    parameter int DEPTH = TBL_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  ovl_t waddr,
    input  rgb_t wdata,
    input  ovl_t raddr,
    output rgb_t rdata
);
    rgb_t entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (we && waddr == ovl_t'(g))
                entry[g] <= wdata;
        end
    end

    // registered read; a same-edge write to the read index is forwarded
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (we && waddr == raddr)
            rdata <= wdata;
        else
            rdata <= entry[raddr];
    end
endmodule

// File: rtl/tc_ctrl_pipe.sv
module tc_ctrl_pipe
    import tc_pkg::*;
#(
    parameter int DEPTH = PIPE_LEN
) (
    input  logic  clk,
    input  logic  rst,
    input  vctl_t din,
    output vctl_t tap [DEPTH]
);
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) tap[0] <= VCTL_IDLE;
                else     tap[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) tap[s] <= VCTL_IDLE;
                else     tap[s] <= tap[s-1];
            end
        end
    end
endmodule

// File: rtl/tc_out_sel.sv
module tc_out_sel
    import tc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  rgb_t direct,
    input  rgb_t table_rgb,
    input  logic ovl_hit,
    input  logic blank,
    output rgb_t rgb
);
    always_ff @(posedge clk) begin
        if (rst || blank)
            rgb <= '0;
        else if (ovl_hit)
            rgb <= table_rgb;
        else
            rgb <= direct;
    end
endmodule

// File: rtl/tc_overlay_path.sv
module tc_overlay_path
    import tc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PIX_W-1:0]    pix_i,
    input  logic                blank_i,
    input  logic                hsync_i,
    input  logic                vsync_i,
    input  logic                tbl_we_i,
    input  logic [OVL_W-1:0]    tbl_addr_i,
    input  logic [RGB_W-1:0]    tbl_data_i,
    output logic [RGB_W-1:0]    rgb_o,
    output logic                blank_o,
    output logic                hsync_o,
    output logic                vsync_o
);
    pix_t  pix;
    rgb_t  direct_c;
    logic  hit_c;
    rgb_t  direct_q;
    logic  hit_q;
    rgb_t  tbl_q;
    rgb_t  rgb_q;
    vctl_t ctl_in;
    vctl_t ctl_tap [PIPE_LEN];

    assign pix    = pix_t'(pix_i);
    assign ctl_in = '{blank: blank_i, hsync: hsync_i, vsync: vsync_i};

    tc_expand u_expand (
        .pix     (pix),
        .rgb     (direct_c),
        .ovl_hit (hit_c)
    );

    // stage 1: direct color alongside the table read
    always_ff @(posedge clk) begin
        if (rst) begin
            direct_q <= '0;
            hit_q    <= 1'b0;
        end else begin
            direct_q <= direct_c;
            hit_q    <= hit_c;
        end
    end

    tc_ovl_table u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we_i),
        .waddr (tbl_addr_i),
        .wdata (rgb_t'(tbl_data_i)),
        .raddr (pix.ovl),
        .rdata (tbl_q)
    );

    tc_ctrl_pipe #(.DEPTH(PIPE_LEN)) u_ctrl (
        .clk (clk),
        .rst (rst),
        .din (ctl_in),
        .tap (ctl_tap)
    );

    // stage 2: overlay priority and blanking
    tc_out_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .direct    (direct_q),
        .table_rgb (tbl_q),
        .ovl_hit   (hit_q),
        .blank     (ctl_tap[0].blank),
        .rgb       (rgb_q)
    );

    assign rgb_o   = rgb_q;
    assign blank_o = ctl_tap[PIPE_LEN-1].blank;
    assign hsync_o = ctl_tap[PIPE_LEN-1].hsync;
    assign vsync_o = ctl_tap[PIPE_LEN-1].vsync;
endmodule

// File: rtl/tc_overlay_chk.sv
module tc_overlay_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] pix_i,
    input logic        blank_i,
    input logic        hsync_i,
    input logic        vsync_i,
    input logic [23:0] rgb_o,
    input logic        blank_o,
    input logic        hsync_o,
    input logic        vsync_o
);
    logic        seen  = 1'b0;
    logic        rst_q = 1'b0;
    logic [1:0]  run   = 2'd0;
    logic [18:0] in_d1 = '0;
    logic [18:0] in_d2 = '0;
    logic        warm;

    always_ff @(posedge clk) begin
        seen  <= 1'b1;
        rst_q <= rst;
        in_d1 <= {blank_i, hsync_i, vsync_i, pix_i};
        in_d2 <= in_d1;
        if (rst)            run <= 2'd0;
        else if (run != 2'd2) run <= run + 2'd1;
    end

    assign warm = (run == 2'd2);

    AST_RESET_QUIET: assert property (@(posedge clk)
        (seen && rst_q) |-> (rgb_o == 24'd0 && blank_o && !hsync_o && !vsync_o)); // R9

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (rgb_o == 24'd0)); // R7

    AST_CTRL_ALIGN: assert property (@(posedge clk) disable iff (rst)
        warm |-> ({blank_o, hsync_o, vsync_o} == in_d2[18:16])); // R6

    AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
        (warm && !in_d2[18] && !in_d2[15]) |->
        (rgb_o == {in_d2[14:10], in_d2[14:12], in_d2[9:5], in_d2[9:7],
                   in_d2[4:0], in_d2[4:2]})); // R3
endmodule

bind tc_overlay_path tc_overlay_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .pix_i   (pix_i),
    .blank_i (blank_i),
    .hsync_i (hsync_i),
    .vsync_i (vsync_i),
    .rgb_o   (rgb_o),
    .blank_o (blank_o),
    .hsync_o (hsync_o),
    .vsync_o (vsync_o)
);

// File: tb/sim_tc_overlay_path.sv
module sim_tc_overlay_path;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] pix_i = '0;
    logic        blank_i = 1'b0, hsync_i = 1'b0, vsync_i = 1'b0;
    logic        tbl_we_i = 1'b0;
    logic [0:0]  tbl_addr_i = '0;
    logic [23:0] tbl_data_i = '0;
    logic [23:0] rgb_o;
    logic        blank_o, hsync_o, vsync_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [23:0] model_tbl [2];
    logic [23:0] q_rgb [$];
    logic [2:0]  q_ctl [$];
    string       q_tag [$];

    always #5 clk = ~clk;

    tc_overlay_path u0 (.*);

    function automatic logic [7:0] grow(input int c5);
        return 8'((c5 * 8) + (c5 / 4));
    endfunction

    task automatic check(input string tag, input logic [23:0] a_rgb, input logic [2:0] a_ctl,
                         input logic [23:0] e_rgb, input logic [2:0] e_ctl);
        checks++;
        if (a_rgb !== e_rgb || a_ctl !== e_ctl) begin
            fails++;
            $display("FAIL %s rgb=%h ctl=%b expected rgb=%h ctl=%b", tag, a_rgb, a_ctl, e_rgb, e_ctl);
        end
    endtask

    // one cycle: drive at falling edge, model the result, compare the pixel from the previous cycle
    task automatic step(input logic [15:0] p, input logic bl, input logic hs, input logic vs,
                        input logic we, input logic wa, input logic [23:0] wd, input string tag);
        int ovl;
        logic [23:0] e;
        pix_i = p; blank_i = bl; hsync_i = hs; vsync_i = vs;
        tbl_we_i = we; tbl_addr_i = wa; tbl_data_i = wd;
        if (we) model_tbl[wa] = wd;           // R8 forwarding: write is visible to this lookup
        ovl = int'(p[15]);
        if (bl) e = 24'd0;
        else if (ovl != 0) e = model_tbl[ovl];
        else e = {grow(int'(p[14:10])), grow(int'(p[9:5])), grow(int'(p[4:0]))};
        q_rgb.push_back(e);
        q_ctl.push_back({bl, hs, vs});
        q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        if (q_rgb.size() == 2)
            check(q_tag.pop_front(), rgb_o, {blank_o, hsync_o, vsync_o},
                  q_rgb.pop_front(), q_ctl.pop_front());
    endtask

    initial begin
        model_tbl[0] = '0;
        model_tbl[1] = '0;
        repeat (3) @(negedge clk);
        check("R9", rgb_o, {blank_o, hsync_o, vsync_o}, 24'd0, 3'b100);
        rst = 1'b0;

        step(16'h8000, 0, 0, 0, 0, 0, 0, "R9");       // cleared table gives black
        step(16'h7FFF, 0, 0, 0, 0, 0, 0, "R2");
        step(16'h0000, 0, 0, 0, 0, 0, 0, "R2");
        step(16'h7C00, 0, 0, 0, 0, 0, 0, "R1");
        step(16'h03E0, 0, 0, 0, 0, 0, 0, "R1");
        step(16'h001F, 0, 0, 0, 0, 0, 0, "R1");
        step(16'h4210, 0, 1, 0, 0, 0, 0, "R3");
        step(16'h2A55, 0, 0, 1, 0, 0, 0, "R3");
        step(16'h0000, 0, 0, 0, 1, 1, 24'h123456, "R8");
        step(16'h9A5A, 0, 0, 0, 0, 0, 0, "R4");
        step(16'h8001, 0, 0, 0, 1, 1, 24'hABCDEF, "R8"); // same-edge write and lookup
        step(16'h0421, 0, 0, 0, 1, 0, 24'hFFFFFF, "R10");
        step(16'h0421, 0, 0, 0, 0, 0, 0, "R10");
        step(16'h8123, 1, 1, 0, 0, 0, 0, "R7");
        step(16'h7FFF, 1, 0, 1, 0, 0, 0, "R7");
        step(16'h1111, 0, 1, 1, 0, 0, 0, "R6");
        step(16'h8000, 0, 0, 1, 0, 0, 0, "R6");
        for (int i = 0; i < 60; i++) begin
            logic [15:0] v;
            v = 16'((i * 40503 + 12345) ^ (i << 7));
            step(v, (i % 7) == 3, (i % 5) == 0, (i % 11) == 2,
                 (i % 9) == 4, 1'(i % 2), 24'((i * 2654435) & 24'hFFFFFF), "R5");
        end
        step(16'h0000, 0, 0, 0, 0, 0, 0, "R5");
        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1;
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule